// File: doc/BRIEF.md
# SPI Serial Memory Slave Engine

This block is the serial front end of a byte-wide memory of 32K locations. It watches a four-wire serial bus (clock, active-low select, data in, data out) plus an active-low pause input, all oversampled by a fast system clock. The first byte after select falls is an opcode. Depending on the opcode, the engine does one of three things. It can pulse a one-cycle command strobe toward a separate protection unit. It can move one status byte in or out. Or it can collect a 16-bit address and then stream data bytes to or from an external byte array, moving the address forward by one after each byte.

Input bits are taken on rising serial-clock edges and output bits change on falling edges, most significant bit first. The data-out enable is high only while read or status data is being driven. Either idle clock level (mode 0 or mode 3) is accepted. Each select window carries exactly one command. A byte cut short by select rising is dropped. While the pause input is low, clock edges are ignored and the output is released; the transfer resumes at the same bit afterwards. A sleep command locks out every opcode except wake.

Top module: `spi_mem_slave`

## Requirements
- R1: The 8-bit opcodes 06h, 04h, B9h and ABh each raise only their own strobe (`cmd_wren`, `cmd_wrdi`, `cmd_sleep`, `cmd_wake`) for one clock. At most one strobe or request output is high in any cycle.
- R2: Opcode 02h is followed by a 16-bit address sent MSB first, of which bit 15 is ignored. Each completed data byte after it gives one `mem_wr_en` pulse with `mem_addr` and `mem_wdata`, and the address then steps up by one.
- R3: Opcode 03h is followed by a 16-bit address. The byte at that address is driven on `spi_so`, MSB first, starting at the falling clock edge after the last address bit. Following bytes come from successive addresses, and each fetch is a single-cycle `mem_rd_en`.
- R4: During streaming the address steps from 7FFFh to 0000h, for both reads and writes.
- R5: Opcode 05h drives `sr_rd_data` on `spi_so`, MSB first, after the opcode. Opcode 01h followed by one byte gives one `sr_wr_en` pulse carrying that byte on `sr_wr_data`.
- R6: `spi_so_oe` is low after reset, while select is high, and during opcode and address bits. It is high only while read or status data is driven.
- R7: While `spi_hold_n` is low, `spi_so_oe` is low and clock edges have no effect. After it rises, the transfer continues at the bit where it paused.
- R8: If select rises before the eighth bit of a write data byte, that byte is not written.
- R9: Only one command runs per select window. Further bytes after a completed command produce no strobe.
- R10: An opcode outside the set listed in R1, R2, R3 and R5 produces no strobe and no request, and `spi_so_oe` stays low until select rises.
- R11: The clock may idle low (mode 0) or high (mode 3) when select falls, and every command behaves the same in both.
- R12: After the B9h strobe, every opcode other than ABh is ignored. ABh raises `cmd_wake` and restores normal decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low select |
| spi_hold_n | input | 1 | Active-low pause |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out value |
| spi_so_oe | output | 1 | Output enable for spi_so; low means high impedance |
| sr_rd_data | input | 8 | Current status byte from the protection unit |
| cmd_wren | output | 1 | Write-enable command strobe |
| cmd_wrdi | output | 1 | Write-disable command strobe |
| cmd_sleep | output | 1 | Sleep command strobe |
| cmd_wake | output | 1 | Wake command strobe |
| sr_wr_en | output | 1 | Status write strobe |
| sr_wr_data | output | 8 | Status byte to write |
| mem_rd_en | output | 1 | Byte read request; data is expected on mem_rdata one clock later |
| mem_wr_en | output | 1 | Byte write request |
| mem_addr | output | 15 | Byte address for read or write |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte returned one clock after mem_rd_en |

## Verification
The properties assume that the serial clock, select and pause inputs each stay put for several system clocks between changes. They also assume that select only changes while the clock is at its idle level, and that pause only changes while select is low and the clock is steady. These conditions keep synchronized edges separate and keep fetch data back before the next falling edge. The stimulus holds every serial level for eight system clocks. It changes select and pause only between bits, and the clock toggles it applies under pause end at the level the clock had before the pause.

// File: rtl/spi_mem_pkg.sv
`timescale 1ns/1ps
package spi_mem_pkg;
  localparam int BYTE_BITS = 8;

  localparam logic [7:0] OPC_WEN_SET = 8'h06;
  localparam logic [7:0] OPC_WEN_CLR = 8'h04;
  localparam logic [7:0] OPC_STAT_RD = 8'h05;
  localparam logic [7:0] OPC_STAT_WR = 8'h01;
  localparam logic [7:0] OPC_MEM_RD  = 8'h03;
  localparam logic [7:0] OPC_MEM_WR  = 8'h02;
  localparam logic [7:0] OPC_NAP     = 8'hB9;
  localparam logic [7:0] OPC_RESUME  = 8'hAB;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_WDATA, ST_RDATA, ST_SRIN, ST_SROUT, ST_DONE
  } eng_state_t;
endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int TOTAL = W * STAGES;

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d = TOTAL'({stg_q, d});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_tx_shift.sv
`timescale 1ns/1ps
module spi_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift,
  output logic         so
);
  logic [W-1:0] sh_q, sh_d;
  logic         so_q, so_d;

  always_comb begin
    sh_d = sh_q;
    so_d = so_q;
    if (load) begin
      sh_d = load_data;
    end else if (shift) begin
      so_d = sh_q[W-1];
      sh_d = {sh_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      so_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      so_q <= so_d;
    end
  end

  assign so = so_q;
endmodule

// File: rtl/spi_mem_ctrl.sv
`timescale 1ns/1ps
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              hold_n_s,
  input  logic              si_s,
  input  logic [7:0]        sr_rd_data,
  input  logic [7:0]        mem_rdata,
  output logic              tx_load,
  output logic [7:0]        tx_data,
  output logic              tx_shift,
  output logic              so_oe,
  output logic              cmd_wren,
  output logic              cmd_wrdi,
  output logic              cmd_sleep,
  output logic              cmd_wake,
  output logic              sr_wr_en,
  output logic [7:0]        sr_wr_data,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int ADDR_FIELD = ((ADDR_W + BYTE_BITS - 1) / BYTE_BITS) * BYTE_BITS;
  localparam int CNT_W      = $clog2(ADDR_FIELD);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_FIELD - 1);

  eng_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [6:0]        rx_q, rx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              is_rd_q, is_rd_d;
  logic              asleep_q, asleep_d;
  logic              oe_q, oe_d;
  logic              sck_prev_q;
  logic              rd_pend_q;
  logic              wren_q, wren_d, wrdi_q, wrdi_d;
  logic              nap_q, nap_d, wake_q, wake_d;
  logic              srwr_q, srwr_d;
  logic [7:0]        srdata_q, srdata_d;
  logic              rd_q, rd_d, wr_q, wr_d;
  logic [7:0]        wdata_q, wdata_d;

  logic       rise, fall;
  logic [7:0] rx_word;

  assign rise    = sck_s & ~sck_prev_q & hold_n_s & ~cs_n_s;
  assign fall    = ~sck_s & sck_prev_q & hold_n_s & ~cs_n_s;
  assign rx_word = {rx_q, si_s};

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    rx_d     = rx_q;
    addr_d   = addr_q;
    is_rd_d  = is_rd_q;
    asleep_d = asleep_q;
    oe_d     = oe_q;
    wren_d   = 1'b0;
    wrdi_d   = 1'b0;
    nap_d    = 1'b0;
    wake_d   = 1'b0;
    srwr_d   = 1'b0;
    srdata_d = srdata_q;
    rd_d     = 1'b0;
    wr_d     = 1'b0;
    wdata_d  = wdata_q;
    tx_load  = rd_pend_q;
    tx_data  = mem_rdata;
    tx_shift = 1'b0;

    if (wr_q) addr_d = addr_q + 1'b1;

    if (cs_n_s) begin
      state_d = ST_OPC;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_OPC: if (rise) begin
          rx_d  = rx_word[6:0];
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            cnt_d   = '0;
            state_d = ST_DONE;
            if (!asleep_q || rx_word == OPC_RESUME) begin
              case (rx_word)
                OPC_WEN_SET: wren_d = 1'b1;
                OPC_WEN_CLR: wrdi_d = 1'b1;
                OPC_NAP: begin
                  nap_d    = 1'b1;
                  asleep_d = 1'b1;
                end
                OPC_RESUME: begin
                  wake_d   = 1'b1;
                  asleep_d = 1'b0;
                end
                OPC_STAT_RD: begin
                  tx_load = 1'b1;
                  tx_data = sr_rd_data;
                  state_d = ST_SROUT;
                end
                OPC_STAT_WR: state_d = ST_SRIN;
                OPC_MEM_RD: begin
                  is_rd_d = 1'b1;
                  state_d = ST_ADDR;
                end
                OPC_MEM_WR: begin
                  is_rd_d = 1'b0;
                  state_d = ST_ADDR;
                end
                default: state_d = ST_DONE;
              endcase
            end
          end
        end
        ST_ADDR: if (rise) begin
          addr_d = {addr_q[ADDR_W-2:0], si_s};
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == LAST_ADDR) begin
            cnt_d = '0;
            if (is_rd_q) begin
              rd_d    = 1'b1;
              state_d = ST_RDATA;
            end else begin
              state_d = ST_WDATA;
            end
          end
        end
        ST_WDATA: if (rise) begin
          rx_d  = rx_word[6:0];
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            cnt_d   = '0;
            wr_d    = 1'b1;
            wdata_d = rx_word;
          end
        end
        ST_RDATA: begin
          if (fall) begin
            tx_shift = 1'b1;
            oe_d     = 1'b1;
          end
          if (rise) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              cnt_d  = '0;
              addr_d = addr_q + 1'b1;
              rd_d   = 1'b1;
            end
          end
        end
        ST_SROUT: begin
          if (fall) begin
            tx_shift = 1'b1;
            oe_d     = 1'b1;
          end
          if (rise) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              cnt_d   = '0;
              oe_d    = 1'b0;
              state_d = ST_DONE;
            end
          end
        end
        ST_SRIN: if (rise) begin
          rx_d  = rx_word[6:0];
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            cnt_d    = '0;
            srwr_d   = 1'b1;
            srdata_d = rx_word;
            state_d  = ST_DONE;
          end
        end
        default: state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_OPC;
      cnt_q      <= '0;
      rx_q       <= '0;
      addr_q     <= '0;
      is_rd_q    <= 1'b0;
      asleep_q   <= 1'b0;
      oe_q       <= 1'b0;
      sck_prev_q <= 1'b0;
      rd_pend_q  <= 1'b0;
      wren_q     <= 1'b0;
      wrdi_q     <= 1'b0;
      nap_q      <= 1'b0;
      wake_q     <= 1'b0;
      srwr_q     <= 1'b0;
      srdata_q   <= '0;
      rd_q       <= 1'b0;
      wr_q       <= 1'b0;
      wdata_q    <= '0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      rx_q       <= rx_d;
      addr_q     <= addr_d;
      is_rd_q    <= is_rd_d;
      asleep_q   <= asleep_d;
      oe_q       <= oe_d;
      sck_prev_q <= sck_s;
      rd_pend_q  <= rd_q;
      wren_q     <= wren_d;
      wrdi_q     <= wrdi_d;
      nap_q      <= nap_d;
      wake_q     <= wake_d;
      srwr_q     <= srwr_d;
      srdata_q   <= srdata_d;
      rd_q       <= rd_d;
      wr_q       <= wr_d;
      wdata_q    <= wdata_d;
    end
  end

  assign so_oe      = oe_q & hold_n_s;
  assign cmd_wren   = wren_q;
  assign cmd_wrdi   = wrdi_q;
  assign cmd_sleep  = nap_q;
  assign cmd_wake   = wake_q;
  assign sr_wr_en   = srwr_q;
  assign sr_wr_data = srdata_q;
  assign mem_rd_en  = rd_q;
  assign mem_wr_en  = wr_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
endmodule

// File: rtl/spi_mem_slave.sv
`timescale 1ns/1ps
module spi_mem_slave #(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_hold_n,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_oe,
  input  logic [7:0]        sr_rd_data,
  output logic              cmd_wren,
  output logic              cmd_wrdi,
  output logic              cmd_sleep,
  output logic              cmd_wake,
  output logic              sr_wr_en,
  output logic [7:0]        sr_wr_data,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  logic       rst_n_int;
  logic [3:0] pins_s;
  logic       sck_s, cs_n_s, hold_n_s, si_s;
  logic       tx_load, tx_shift;
  logic [7:0] tx_data;

  spi_pin_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_int)
  );

  spi_pin_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0110)) u_pin_sync (
    .clk(clk), .rst_n(rst_n_int),
    .d({spi_sck, spi_cs_n, spi_hold_n, spi_si}), .q(pins_s)
  );

  assign {sck_s, cs_n_s, hold_n_s, si_s} = pins_s;

  spi_mem_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_int),
    .sck_s(sck_s), .cs_n_s(cs_n_s), .hold_n_s(hold_n_s), .si_s(si_s),
    .sr_rd_data(sr_rd_data), .mem_rdata(mem_rdata),
    .tx_load(tx_load), .tx_data(tx_data), .tx_shift(tx_shift),
    .so_oe(spi_so_oe),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_sleep(cmd_sleep), .cmd_wake(cmd_wake),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  spi_tx_shift #(.W(8)) u_tx (
    .clk(clk), .rst_n(rst_n_int),
    .load(tx_load), .load_data(tx_data), .shift(tx_shift), .so(spi_so)
  );
endmodule

// File: rtl/spi_mem_slave_chk.sv
`timescale 1ns/1ps
module spi_mem_slave_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n_s,
  input logic              hold_n_s,
  input logic              spi_so_oe,
  input logic              cmd_wren,
  input logic              cmd_wrdi,
  input logic              cmd_sleep,
  input logic              cmd_wake,
  input logic              sr_wr_en,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_addr
);
  a_r1_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wren, cmd_wrdi, cmd_sleep, cmd_wake, sr_wr_en, mem_rd_en, mem_wr_en}));

  a_r2_write_steps: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  a_r3_fetch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && $past(cs_n_s)) |-> !spi_so_oe);

  a_r7_hold_no_action: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n_s |=> !(cmd_wren || cmd_wrdi || cmd_sleep || cmd_wake ||
                    sr_wr_en || mem_rd_en || mem_wr_en));
endmodule

bind spi_mem_slave spi_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n_int), .cs_n_s(cs_n_s), .hold_n_s(hold_n_s),
  .spi_so_oe(spi_so_oe), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
  .cmd_sleep(cmd_sleep), .cmd_wake(cmd_wake), .sr_wr_en(sr_wr_en),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr)
);

// File: tb/sim_spi_mem_slave.sv
`timescale 1ns/1ps
module sim_spi_mem_slave;
  localparam int HP = 160;  // half serial period: eight system clocks

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, sck, cs_n, hold_n, si;
  logic        so, so_oe;
  logic [7:0]  sr_rd_data;
  logic        cmd_wren, cmd_wrdi, cmd_sleep, cmd_wake, sr_wr_en;
  logic [7:0]  sr_wr_data;
  logic        mem_rd_en, mem_wr_en;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  spi_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_hold_n(hold_n), .spi_si(si), .spi_so(so), .spi_so_oe(so_oe),
    .sr_rd_data(sr_rd_data), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_sleep(cmd_sleep), .cmd_wake(cmd_wake), .sr_wr_en(sr_wr_en),
    .sr_wr_data(sr_wr_data), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // behavioural byte array
  logic [7:0] mem [int];
  always @(posedge clk) begin
    if (mem_wr_en) mem[int'(mem_addr)] = mem_wdata;
    if (mem_rd_en) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
  end

  // expected contents, kept from the requirements only
  logic [7:0] exp_mem [int];
  function automatic logic [7:0] exp_rd(input int a);
    return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
  endfunction

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard: kinds 1 wren, 2 wrdi, 3 sleep, 4 wake, 5 status write, 6 memory write
  typedef struct {int kind; int addr; int data; string req;} ev_t;
  ev_t evq[$];

  task automatic expect_ev(input int kind, input int addr, input int data, input string req);
    ev_t e;
    e.kind = kind; e.addr = addr; e.data = data; e.req = req;
    evq.push_back(e);
    if (kind == 6) exp_mem[addr] = data[7:0];
  endtask

  task automatic observe(input int kind, input int addr, input int data);
    ev_t e;
    if (evq.size() == 0) begin
      check(1'b0, "unexpected event R9/R10/R12", kind, 0);
    end else begin
      e = evq.pop_front();
      check(e.kind == kind, e.req, kind, e.kind);
      check(e.addr == addr && e.data == data, e.req, (addr << 8) | data,
            (e.addr << 8) | e.data);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_wren)  observe(1, 0, 0);
      if (cmd_wrdi)  observe(2, 0, 0);
      if (cmd_sleep) observe(3, 0, 0);
      if (cmd_wake)  observe(4, 0, 0);
      if (sr_wr_en)  observe(5, 0, int'(sr_wr_data));
      if (mem_wr_en) observe(6, int'(mem_addr), int'(mem_wdata));
    end
  end

  // serial driver
  task automatic sel(input bit m3);
    sck = m3;
    #(HP);
    cs_n = 1'b0;
    #(HP);
  endtask

  task automatic desel(input bit m3);
    if (!m3) sck = 1'b0;
    #(HP);
    cs_n = 1'b1;
    #(4*HP);
  endtask

  task automatic xbits(input logic [7:0] b, input int nbits, input int hold_at,
                       input bit hold_oe_chk, output logic [7:0] r,
                       output logic oe_all, output logic oe_any);
    r = 8'h00; oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      if (i == hold_at) begin
        hold_n = 1'b0;
        #(HP);
        if (hold_oe_chk) check(so_oe == 1'b0, "R7 output released under hold", so_oe, 0);
        for (int k = 0; k < 3; k++) begin
          sck = 1'b0; si = ~si; #(HP);
          sck = 1'b1; #(HP);
        end
        hold_n = 1'b1;
        #(HP);
      end
      sck = 1'b0;
      si = b[i];
      #(HP);
      r[i] = so;
      oe_all = oe_all & so_oe;
      oe_any = oe_any | so_oe;
      sck = 1'b1;
      #(HP);
    end
  endtask

  task automatic xb(input logic [7:0] b, output logic [7:0] r, output logic oe_any);
    logic oa;
    xbits(b, 8, -1, 1'b0, r, oa, oe_any);
  endtask

  task automatic send_cmd(input bit m3, input logic [7:0] op, input int extra);
    logic [7:0] r; logic oe;
    sel(m3);
    xb(op, r, oe);
    for (int k = 0; k < extra; k++) xb(8'h06, r, oe);
    desel(m3);
  endtask

  logic [7:0] wbuf [0:7];

  task automatic wr_bytes(input bit m3, input int a16, input int n, input string req);
    logic [7:0] r; logic oe;
    sel(m3);
    xb(8'h02, r, oe);
    xb(a16[15:8], r, oe);
    xb(a16[7:0], r, oe);
    for (int k = 0; k < n; k++) begin
      expect_ev(6, (a16 + k) & 32'h7FFF, int'(wbuf[k]), req);
      xb(wbuf[k], r, oe);
    end
    desel(m3);
  endtask

  task automatic rd_check(input bit m3, input int a16, input int n, input string req);
    logic [7:0] r; logic oe, oa, oany;
    sel(m3);
    xb(8'h03, r, oe);
    check(oe == 1'b0, "R6 no drive during opcode", oe, 0);
    xb(a16[15:8], r, oe);
    xb(a16[7:0], r, oany);
    check((oe | oany) == 1'b0, "R6 no drive during address", oe | oany, 0);
    for (int k = 0; k < n; k++) begin
      xbits(8'h00, 8, -1, 1'b0, r, oa, oany);
      check(r == exp_rd((a16 + k) & 32'h7FFF), req, r, exp_rd((a16 + k) & 32'h7FFF));
      check(oa == 1'b1, "R6 drive during read data", oa, 1);
    end
    desel(m3);
  endtask

  task automatic settle();
    #(8*HP);
    check(evq.size() == 0, "scoreboard drained R1/R2/R5", evq.size(), 0);
  endtask

  initial begin
    logic [7:0] r; logic oe, oa, oany;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; hold_n = 1'b1; si = 1'b0;
    sr_rd_data = 8'hC9;
    #(200);
    rst_n = 1'b1;
    #(200);
    // reset state (R6)
    check(so_oe == 1'b0, "R6 reset output enable", so_oe, 0);
    check({cmd_wren, cmd_wrdi, cmd_sleep, cmd_wake, sr_wr_en, mem_wr_en, mem_rd_en} == 7'd0,
          "R1 reset strobes idle", 0, 0);

    // R1 command strobes, R11 in both modes, R9 extra bytes ignored
    expect_ev(1, 0, 0, "R1 wren mode0");
    send_cmd(1'b0, 8'h06, 0);
    expect_ev(2, 0, 0, "R11 wrdi mode3");
    send_cmd(1'b1, 8'h04, 0);
    expect_ev(1, 0, 0, "R9 wren once per window");
    send_cmd(1'b0, 8'h06, 2);
    settle();

    // R2 write with bit 15 set, R3 read back, R11 mode3 read
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h7E;
    wr_bytes(1'b0, 32'h8123, 3, "R2 write stream");
    rd_check(1'b0, 32'h0123, 3, "R3 read stream mode0");
    rd_check(1'b1, 32'h8123, 3, "R11 read stream mode3");
    wbuf[0] = 8'h5C; wbuf[1] = 8'hE1;
    wr_bytes(1'b1, 32'h1FFE, 2, "R11 write stream mode3");
    rd_check(1'b0, 32'h1FFE, 2, "R11 read after mode3 write");

    // R4 wrap
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_bytes(1'b0, 32'h7FFF, 2, "R4 write wrap");
    rd_check(1'b1, 32'h7FFF, 2, "R4 read wrap");
    settle();

    // R5 status read and write
    sel(1'b0);
    xb(8'h05, r, oe);
    xbits(8'h00, 8, -1, 1'b0, r, oa, oany);
    check(r == 8'hC9, "R5 status read", r, 8'hC9);
    check(oa == 1'b1, "R6 drive during status read", oa, 1);
    desel(1'b0);
    sel(1'b1);
    xb(8'h01, r, oe);
    expect_ev(5, 0, 8'h8C, "R5 status write");
    xb(8'h8C, r, oe);
    desel(1'b1);
    settle();

    // R7 hold during a write byte and during a read byte
    sel(1'b0);
    xb(8'h02, r, oe); xb(8'h02, r, oe); xb(8'h00, r, oe);
    expect_ev(6, 16'h0200, 8'h5A, "R7 write resumes after hold");
    xbits(8'h5A, 8, 3, 1'b0, r, oa, oany);
    desel(1'b0);
    sel(1'b1);
    xb(8'h03, r, oe); xb(8'h02, r, oe); xb(8'h00, r, oe);
    xbits(8'h00, 8, 4, 1'b1, r, oa, oany);
    check(r == 8'h5A, "R7 read resumes after hold", r, 8'h5A);
    check(oa == 1'b1, "R7 drive restored after hold", oa, 1);
    desel(1'b1);
    settle();

    // R8 partial byte dropped
    sel(1'b0);
    xb(8'h02, r, oe); xb(8'h03, r, oe); xb(8'h00, r, oe);
    expect_ev(6, 16'h0300, 8'h99, "R8 full byte written");
    xb(8'h99, r, oe);
    xbits(8'hFF, 5, -1, 1'b0, r, oa, oany);
    desel(1'b0);
    settle();
    rd_check(1'b0, 32'h0300, 2, "R8 partial byte not stored");

    // R10 unknown opcode
    sel(1'b0);
    xb(8'h5F, r, oe);
    xb(8'h02, r, oe);
    xb(8'h00, r, oany);
    check((oe | oany) == 1'b0, "R10 unknown opcode keeps output off", oe | oany, 0);
    desel(1'b0);
    settle();

    // R12 sleep lockout
    expect_ev(3, 0, 0, "R12 sleep strobe");
    send_cmd(1'b0, 8'hB9, 0);
    send_cmd(1'b0, 8'h06, 0);
    sel(1'b1);
    xb(8'h02, r, oe); xb(8'h04, r, oe); xb(8'h00, r, oe); xb(8'h77, r, oe);
    desel(1'b1);
    sel(1'b0);
    xb(8'h05, r, oe);
    xb(8'h00, r, oany);
    check(oany == 1'b0, "R12 status read ignored while asleep", oany, 0);
    desel(1'b0);
    settle();
    expect_ev(4, 0, 0, "R12 wake strobe");
    send_cmd(1'b1, 8'hAB, 0);
    expect_ev(1, 0, 0, "R12 decoding restored");
    send_cmd(1'b0, 8'h06, 0);
    settle();
    rd_check(1'b0, 32'h0400, 1, "R12 write ignored while asleep");

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule